// File: doc/BRIEF.md
# Receive Frame Queue Read Port

This block is the host-side read port of the receive frame buffer in a single-port network controller. The receive path pushes 16-bit words into an internal circular memory and marks the last word of each frame. Each stored frame is a status word, then a length word, then the packet bytes packed two per word, the trailing CRC included. A frame carries at most 2000 packet bytes.

The host drains frames through one 16-bit data register. Reads count only while the transfer-start input is held high. An optional auto-advance moves the in-frame position one word (two bytes) on each read. When auto-release is enabled, the head frame is released as soon as its last word has been read; otherwise the host releases it with a pulse. Two more options act on the words presented to the host. One swaps the two bytes of every word taken from memory, for big-endian hosts. The other inserts a two-byte zero pad between the length word and the packet data, so that the IP header lands on a four-byte boundary. Two header outputs show the status and the 12-bit length of the frame at the head of the queue without disturbing the read position.

Top module: `rxq_read_port`

## Requirements
- R1: After reset, rd_valid, frame_done and rd_underflow are 0 and hdr_status and hdr_count are 0, because the queue is empty.
- R2: A read is accepted only in a cycle where rd_en and dma_start are both high. Its word appears on rd_data, with rd_valid high, one cycle later. A rd_en while dma_start is low produces no rd_valid. With auto_inc_en set, a frame reads as the status word, then the length word, then the packet words.
- R3: With auto_inc_en low, repeated reads return the same word and the position does not move.
- R4: With ip_pad_en set, the read that follows the length word returns 16'h0000, and packet data follows after it.
- R5: With big_endian set, every word taken from memory is returned as {w[7:0], w[15:8]}: the status word, the length word and the packet words alike. The pad word stays 16'h0000.
- R6: frame_done is high together with rd_valid on the read of the frame's last word, and only when auto_inc_en is set. The frame holds ceil(L/2) packet words, where L is the 12-bit length. A length of 0 makes the length word (or the pad word, if the pad is enabled) the last word.
- R7: With auto_deq_en set, the frame is released when frame_done is raised, and the next read returns the next frame's status word. With auto_deq_en low, the next read returns the same frame's status word again.
- R8: A read accepted while no complete frame is queued returns 16'h0000 with rd_underflow and rd_valid both high.
- R9: hdr_status shows the head frame's status word and hdr_count shows bits [11:0] of its length word, in memory byte order. Both are 0 when the queue is empty.
- R10: A release_req pulse removes the head frame and returns the position to the status word. When the queue is empty, release_req has no effect.
- R11: A rising edge on dma_start returns the read position to the head frame's status word.
- R12: Bits [15:12] of the stored length word play no part in the frame's word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receive path writes one word |
| wr_data | input | 16 | Word written into the queue |
| wr_eof | input | 1 | Marks the written word as the last of its frame; the frame is then committed |
| dma_start | input | 1 | Host transfer active; a rising edge rewinds the position |
| rd_en | input | 1 | Host reads the data register |
| auto_inc_en | input | 1 | Advance the position on every read |
| auto_deq_en | input | 1 | Release the frame when its last word is read |
| ip_pad_en | input | 1 | Insert a two-byte zero pad before the packet data |
| big_endian | input | 1 | Swap the bytes of words taken from memory |
| release_req | input | 1 | Pulse that releases the head frame |
| rd_data | output | 16 | Data register read result |
| rd_valid | output | 1 | rd_data holds a new read result |
| frame_done | output | 1 | The read was the frame's last word |
| rd_underflow | output | 1 | The read found no frame queued |
| hdr_status | output | 16 | Head frame status word |
| hdr_count | output | 12 | Head frame byte length |

## Verification
The hardest cases to reach are the interactions at a frame boundary. Examples are a release that arrives after the final read, a zero-length frame whose last word is the length word itself, and a rewind caused by toggling dma_start partway through a frame. The stimulus queues four frames of different lengths, including an odd length, a zero length and a length word with its upper bits set. It then walks them in turn under changing settings for swapping, padding, auto-advance and auto-release. A behavioural queue model checks every cycle, so each of these boundaries is compared at the exact clock where it occurs.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int CNT_W  = 12;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        WK_STAT,
        WK_CNT,
        WK_PAD,
        WK_DATA
    } word_kind_e;

    typedef struct packed {
        logic       fire;
        logic       empty;
        logic       last;
        word_kind_e kind;
    } rd_req_t;

    function automatic logic [WORD_W-1:0] swap16(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    function automatic logic [CNT_W:0] words_for(input logic [CNT_W-1:0] n);
        logic [CNT_W:0] t;
        t = {1'b0, n} + {{CNT_W{1'b0}}, 1'b1};
        return t >> 1;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_eof,
    input  logic              deq,
    input  logic [AW:0]       deq_words,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] head_w0,
    output logic [WORD_W-1:0] head_w1,
    output logic [AW-1:0]     head_ptr,
    output logic              have_frame
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW:0]       used;
    logic [AW:0]       frames;
    logic              wr_ok;
    logic              commit;

    assign wr_ok  = wr_en && (used != (AW+1)'(DEPTH));
    assign commit = wr_ok && wr_eof;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            head_ptr <= '0;
            used     <= '0;
            frames   <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (deq) begin
                head_ptr <= head_ptr + deq_words[AW-1:0];
            end
            used   <= used + (AW+1)'(wr_ok) - (deq ? deq_words : '0);
            frames <= frames + (AW+1)'(commit) - (AW+1)'(deq);
        end
    end

    assign rd_word    = mem[rd_addr];
    assign head_w0    = mem[head_ptr];
    assign head_w1    = mem[head_ptr + 1'b1];
    assign have_frame = (frames != '0);

    p_deq_nonempty_r10: assert property (@(posedge clk) disable iff (rst)
        deq |-> (frames != '0));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        used <= (AW+1)'(DEPTH));

endmodule

// File: rtl/rxq_rdptr.sv
module rxq_rdptr
    import rxq_pkg::*;
#(
    parameter int AW = 11,
    localparam int POS_W = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_start,
    input  logic              rd_en,
    input  logic              auto_inc_en,
    input  logic              auto_deq_en,
    input  logic              ip_pad_en,
    input  logic              release_req,
    input  logic              have_frame,
    input  logic [AW-1:0]     head_ptr,
    input  logic [WORD_W-1:0] cnt_word,
    output logic [AW-1:0]     rd_addr,
    output rd_req_t           req,
    output logic              deq,
    output logic [AW:0]       deq_words
);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] p0;
    logic [POS_W-1:0] last_pos;
    logic [POS_W-1:0] data_off;
    logic [CNT_W:0]   nwords;
    logic             dma_q;
    logic             fire;
    logic             rise;
    logic             done;
    word_kind_e       kind;

    assign nwords   = words_for(cnt_word[CNT_W-1:0]);
    assign p0       = ip_pad_en ? POS_W'(3) : POS_W'(2);
    assign last_pos = p0 + POS_W'(nwords) - POS_W'(1);
    assign data_off = pos - p0;

    assign fire = rd_en && dma_start;
    assign rise = dma_start && !dma_q;
    assign done = fire && have_frame && auto_inc_en && (pos == last_pos);
    assign deq  = have_frame && (release_req || (done && auto_deq_en));
    assign deq_words = (AW+1)'(nwords) + (AW+1)'(2);

    always_comb begin
        if (pos == POS_W'(0)) begin
            kind = WK_STAT;
        end else if (pos == POS_W'(1)) begin
            kind = WK_CNT;
        end else if (ip_pad_en && pos == POS_W'(2)) begin
            kind = WK_PAD;
        end else begin
            kind = WK_DATA;
        end
    end

    always_comb begin
        case (kind)
            WK_CNT:  rd_addr = head_ptr + AW'(1);
            WK_DATA: rd_addr = head_ptr + AW'(2) + AW'(data_off);
            default: rd_addr = head_ptr;
        endcase
    end

    assign req.fire  = fire;
    assign req.empty = !have_frame;
    assign req.last  = done;
    assign req.kind  = kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            dma_q <= 1'b0;
        end else begin
            dma_q <= dma_start;
            if (deq || done || rise) begin
                pos <= '0;
            end else if (fire && have_frame && auto_inc_en) begin
                pos <= pos + POS_W'(1);
            end
        end
    end

    p_rise_rewinds_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_start) |=> (pos == '0));

    p_hold_noinc_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && !auto_inc_en && !deq && !rise) |=> $stable(pos));

endmodule

// File: rtl/rxq_lane.sv
module rxq_lane
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rd_req_t           req,
    input  logic [WORD_W-1:0] word,
    input  logic              big_endian,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              frame_done,
    output logic              rd_underflow
);

    logic [WORD_W-1:0] shaped;

    always_comb begin
        if (req.empty || req.kind == WK_PAD) begin
            shaped = '0;
        end else if (big_endian) begin
            shaped = swap16(word);
        end else begin
            shaped = word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data      <= '0;
            rd_valid     <= 1'b0;
            frame_done   <= 1'b0;
            rd_underflow <= 1'b0;
        end else begin
            rd_valid     <= req.fire;
            frame_done   <= req.fire && req.last;
            rd_underflow <= req.fire && req.empty;
            if (req.fire) begin
                rd_data <= shaped;
            end
        end
    end

    p_underflow_zero_r8: assert property (@(posedge clk) disable iff (rst)
        rd_underflow |-> (rd_valid && rd_data == '0));

    p_done_valid_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (rd_valid && !rd_underflow));

    p_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (req.fire && !req.empty && req.kind == WK_PAD) |=> (rd_data == '0));

endmodule

// File: rtl/rxq_read_port.sv
module rxq_read_port
    import rxq_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_eof,
    input  logic              dma_start,
    input  logic              rd_en,
    input  logic              auto_inc_en,
    input  logic              auto_deq_en,
    input  logic              ip_pad_en,
    input  logic              big_endian,
    input  logic              release_req,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              frame_done,
    output logic              rd_underflow,
    output logic [WORD_W-1:0] hdr_status,
    output logic [CNT_W-1:0]  hdr_count
);

    logic [AW-1:0]     rd_addr;
    logic [AW-1:0]     head_ptr;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] head_w0;
    logic [WORD_W-1:0] head_w1;
    logic              have_frame;
    logic              deq;
    logic [AW:0]       deq_words;
    rd_req_t           req;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_eof     (wr_eof),
        .deq        (deq),
        .deq_words  (deq_words),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .head_w0    (head_w0),
        .head_w1    (head_w1),
        .head_ptr   (head_ptr),
        .have_frame (have_frame)
    );

    rxq_rdptr #(.AW(AW)) u_rdptr (
        .clk         (clk),
        .rst         (rst),
        .dma_start   (dma_start),
        .rd_en       (rd_en),
        .auto_inc_en (auto_inc_en),
        .auto_deq_en (auto_deq_en),
        .ip_pad_en   (ip_pad_en),
        .release_req (release_req),
        .have_frame  (have_frame),
        .head_ptr    (head_ptr),
        .cnt_word    (head_w1),
        .rd_addr     (rd_addr),
        .req         (req),
        .deq         (deq),
        .deq_words   (deq_words)
    );

    rxq_lane u_lane (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .word         (rd_word),
        .big_endian   (big_endian),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .frame_done   (frame_done),
        .rd_underflow (rd_underflow)
    );

    assign hdr_status = have_frame ? head_w0 : '0;
    assign hdr_count  = have_frame ? head_w1[CNT_W-1:0] : '0;

endmodule

// File: tb/rxq_read_port_bench.sv
module rxq_read_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_eof = 1'b0;
    logic        dma_start = 1'b0;
    logic        rd_en = 1'b0;
    logic        auto_inc_en = 1'b1;
    logic        auto_deq_en = 1'b0;
    logic        ip_pad_en = 1'b0;
    logic        big_endian = 1'b0;
    logic        release_req = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        frame_done;
    logic        rd_underflow;
    logic [15:0] hdr_status;
    logic [11:0] hdr_count;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    rxq_read_port u_rxq_read_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
        .dma_start(dma_start), .rd_en(rd_en), .auto_inc_en(auto_inc_en),
        .auto_deq_en(auto_deq_en), .ip_pad_en(ip_pad_en), .big_endian(big_endian),
        .release_req(release_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .frame_done(frame_done), .rd_underflow(rd_underflow),
        .hdr_status(hdr_status), .hdr_count(hdr_count)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: a word queue plus committed frame lengths
    logic [15:0] mq[$];
    int          fl[$];
    int          cur_len;
    int          mpos;
    bit          mdma_q;
    bit          e_valid, e_done, e_uf;
    logic [15:0] e_data;

    always @(posedge clk) begin
        bit fire, have, dn, dq;
        int p0, nw;
        logic [15:0] w;
        if (rst) begin
            mq.delete(); fl.delete();
            cur_len = 0; mpos = 0; mdma_q = 0;
            e_valid = 0; e_done = 0; e_uf = 0; e_data = '0;
        end else begin
            fire = rd_en && dma_start;
            have = fl.size() > 0;
            dn = 0; dq = 0;
            p0 = ip_pad_en ? 3 : 2;
            nw = have ? ((int'(mq[1] & 16'h0FFF) + 1) / 2) : 0;
            e_valid = fire; e_done = 0; e_uf = 0;
            if (fire) begin
                if (!have) begin
                    e_data = '0; e_uf = 1;
                end else begin
                    if (mpos == 0) w = mq[0];
                    else if (mpos == 1) w = mq[1];
                    else if (ip_pad_en && mpos == 2) w = '0;
                    else w = mq[2 + mpos - p0];
                    if (big_endian) w = {w[7:0], w[15:8]};
                    e_data = w;
                    if (auto_inc_en && mpos == p0 + nw - 1) begin
                        dn = 1; e_done = 1;
                    end
                end
            end
            if (have && (release_req || (dn && auto_deq_en))) dq = 1;
            if (dq || dn) mpos = 0;
            else if (dma_start && !mdma_q) mpos = 0;
            else if (fire && have && auto_inc_en) mpos++;
            mdma_q = dma_start;
            if (dq) begin
                for (int i = 0; i < fl[0]; i++) void'(mq.pop_front());
                void'(fl.pop_front());
            end
            if (wr_en) begin
                mq.push_back(wr_data);
                cur_len++;
                if (wr_eof) begin
                    fl.push_back(cur_len);
                    cur_len = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 model rd_valid", 16'(rd_valid), 16'(e_valid));
            chk("R2 model rd_data", rd_data, e_data);
            chk("R6 model frame_done", 16'(frame_done), 16'(e_done));
            chk("R8 model rd_underflow", 16'(rd_underflow), 16'(e_uf));
            chk("R9 model hdr_status", hdr_status, fl.size() > 0 ? mq[0] : 16'h0);
            chk("R9 model hdr_count", 16'(hdr_count), fl.size() > 0 ? (mq[1] & 16'h0FFF) : 16'h0);
        end
    end

    task automatic wframe(input logic [15:0] st, input logic [15:0] cw, input int f);
        int nw;
        nw = (int'(cw & 16'h0FFF) + 1) / 2;
        for (int k = 0; k < nw + 2; k++) begin
            wr_en = 1'b1;
            wr_data = (k == 0) ? st : (k == 1) ? cw : 16'(16'hA000 + f * 16 + (k - 2));
            wr_eof = (k == nw + 1);
            @(negedge clk);
        end
        wr_en = 1'b0; wr_eof = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [15:0] exp_d, input logic exp_done);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " data"}, rd_data, exp_d);
        chk({tag, " done"}, 16'(frame_done), 16'(exp_done));
    endtask

    task automatic pulse_release();
        release_req = 1'b1;
        @(negedge clk);
        release_req = 1'b0;
    endtask

    task automatic rewind();
        dma_start = 1'b0;
        @(negedge clk);
        dma_start = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_valid", 16'(rd_valid), 16'h0);
        chk("R1 frame_done", 16'(frame_done), 16'h0);
        chk("R1 rd_underflow", 16'(rd_underflow), 16'h0);
        chk("R1 hdr_status", hdr_status, 16'h0);

        // R2 read with dma_start low is ignored
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R2 ignored rd_valid", 16'(rd_valid), 16'h0);

        // R8 empty read
        dma_start = 1'b1; @(negedge clk);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R8 empty data", rd_data, 16'h0);
        chk("R8 underflow", 16'(rd_underflow), 16'h1);

        // Frame A: 5 bytes -> 3 packet words
        wframe(16'h1234, 16'h0005, 1);
        @(negedge clk);
        chk("R9 hdr_status A", hdr_status, 16'h1234);
        chk("R9 hdr_count A", 16'(hdr_count), 16'h0005);
        rewind();
        rd("R2 A stat", 16'h1234, 1'b0);
        rd("R2 A cnt", 16'h0005, 1'b0);
        rd("R2 A d0", 16'hA010, 1'b0);
        rd("R6 A d1", 16'hA011, 1'b0);
        rd("R6 A d2 last odd", 16'hA012, 1'b1);
        rd("R7 no deq restart", 16'h1234, 1'b0);

        // Frame B: length word with upper bits set, 4 bytes
        wframe(16'h00BB, 16'hF004, 2);
        pulse_release();
        chk("R10 hdr after release", hdr_status, 16'h00BB);
        chk("R12 hdr_count masked", 16'(hdr_count), 16'h0004);
        big_endian = 1'b1; ip_pad_en = 1'b1;
        rd("R5 B stat swapped", 16'hBB00, 1'b0);
        rd("R5 B cnt swapped", 16'h04F0, 1'b0);
        rd("R4 B pad", 16'h0000, 1'b0);
        rd("R5 B d0 swapped", 16'h20A0, 1'b0);
        rd("R12 B d1 last", 16'h21A0, 1'b1);
        big_endian = 1'b0; ip_pad_en = 1'b0;

        // Frames C (zero length) and D (3 bytes)
        wframe(16'h0C0C, 16'h0000, 3);
        wframe(16'h0D0D, 16'h0003, 4);
        auto_deq_en = 1'b1;
        rd("R2 B stat", 16'h00BB, 1'b0);
        rd("R2 B cnt", 16'hF004, 1'b0);
        rd("R2 B d0", 16'hA020, 1'b0);
        rd("R6 B d1", 16'hA021, 1'b1);
        chk("R7 auto deq hdr", hdr_status, 16'h0C0C);
        rd("R7 C stat", 16'h0C0C, 1'b0);
        rd("R6 C zero len last", 16'h0000, 1'b1);
        chk("R7 hdr D", hdr_status, 16'h0D0D);

        auto_inc_en = 1'b0;
        rd("R3 hold 1", 16'h0D0D, 1'b0);
        rd("R3 hold 2", 16'h0D0D, 1'b0);
        auto_inc_en = 1'b1;
        rd("R3 resume stat", 16'h0D0D, 1'b0);
        rd("R3 resume cnt", 16'h0003, 1'b0);
        rewind();
        rd("R11 rewind stat", 16'h0D0D, 1'b0);
        rd("R11 cnt", 16'h0003, 1'b0);
        rd("R2 D d0", 16'hA040, 1'b0);
        rd("R6 D d1", 16'hA041, 1'b1);
        chk("R7 empty hdr", hdr_status, 16'h0);

        pulse_release();
        chk("R10 release empty hdr", hdr_status, 16'h0);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R10 release empty underflow", 16'(rd_underflow), 16'h1);
        chk("R8 underflow data", rd_data, 16'h0);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule